// File: doc/BRIEF.md
# Processor Sleep and Wakeup Controller

This block decides when a processor core drops into a low-power sleep state and when it comes back. The core signals a sleep request in one of three ways: a wait-for-interrupt strobe, a wait-for-event strobe, or an exception-return strobe while the sleep-on-exit control bit is set. The block then watches the per-interrupt pending, enable and priority lines, the current execution priority, the two mask bits and a one-bit event register. From these it decides when to wake the core, and whether the core may take the handler once it is awake.

The wake rule depends on how sleep was entered. An interrupt-type sleep (wait-for-interrupt or sleep-on-exit) ignores the priority mask when it decides to wake. The handler is then held off until that mask is cleared. An event-type sleep wakes on an exception that can actually be entered now, or on an event. When the send-event-on-pend bit is set, any fresh rise of a pending bit counts as an event. When a sleep is entered with the deep-sleep bit set, the block raises a deep flag. Before the core resumes, it also spends a fixed number of restore cycles, taken from a parameter.

Top module: `slumber_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `sleeping_o`, `deep_o`, `wic_en_o`, `wake_o` and `take_exc_o` are all 0, and the event register is clear.
- R2: In the run state, a `wfi_i` pulse, or an `exc_ret_i` pulse while `sleep_on_exit_i` is 1, sets `sleeping_o` on the next clock. An `exc_ret_i` pulse with `sleep_on_exit_i` at 0 leaves the core running.
- R3: An interrupt-type sleep ends only when some interrupt i has pending=1, enable=1, a priority field (bits i*PRIO_W upward of `irq_prio_i`) strictly below `cur_prio_i`, and `faultmask_i` is 0. A lower value means a more urgent interrupt. Equal priority, a disabled interrupt, or an event does not wake it.
- R4: `take_exc_o` is 1 only in the run state, while such a qualifying interrupt exists and both mask bits are 0. A core woken with `primask_i` at 1 sees `take_exc_o` at 0 until `primask_i` falls.
- R5: An event-type sleep ends when a qualifying interrupt exists with both mask bits at 0, or when an event is present. With `primask_i` at 1 and no event, it does not wake.
- R6: With `send_ev_on_pend_i` at 1, a 0-to-1 change of any pending bit, sampled on the clock, is an event. This holds even when the interrupt is disabled or its priority is too low, and it wakes an event-type sleep. A bit that stays at 1 does not produce an event. With `send_ev_on_pend_i` at 0, no event is made.
- R7: The event register keeps an event until a wait-for-event consumes it. A `wfe_i` pulse that arrives while the register is set clears it and leaves the core running with no wake pulse. The next `wfe_i` then sleeps. Waking an event-type sleep also consumes the register.
- R8: `wic_en_o` is 1 exactly while `sleeping_o` is 1 and `deep_i` is 1. `deep_o` is 1 while asleep from an entry made with `deep_i` at 1.
- R9: A wake from deep sleep keeps `sleeping_o` high for RESTORE_CYC extra cycles. Only after those cycles does `wake_o` pulse, so the wake comes RESTORE_CYC cycles later than from a normal sleep.
- R10: `wake_o` lasts exactly one cycle, and the block is in the run state while it is high. A `wfi_i` or `wfe_i` pulse that arrives while asleep is ignored and does not consume the event register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| exc_ret_i | input | 1 | Handler return to thread mode strobe |
| sleep_on_exit_i | input | 1 | Sleep on handler return enable |
| send_ev_on_pend_i | input | 1 | Newly pending interrupts generate events |
| deep_i | input | 1 | Deep-sleep select |
| primask_i | input | 1 | Priority mask bit |
| faultmask_i | input | 1 | Fault mask bit |
| irq_pend_i | input | N_IRQ | Per-interrupt pending |
| irq_en_i | input | N_IRQ | Per-interrupt enable |
| irq_prio_i | input | N_IRQ*PRIO_W | Packed priorities, interrupt i at bits i*PRIO_W upward |
| cur_prio_i | input | PRIO_W | Current execution priority |
| sleeping_o | output | 1 | Core is asleep or restoring |
| deep_o | output | 1 | Current sleep is a deep sleep |
| wic_en_o | output | 1 | Wakeup interrupt controller enable |
| wake_o | output | 1 | One-cycle wake pulse |
| take_exc_o | output | 1 | Core may enter the handler |

## Verification
The bench goes after the edges of the priority compare. At equal priority, a design that used a non-strict compare would wake. It also checks the mask split between the two sleep kinds. A design that applied the priority mask to interrupt-type wake would stay asleep forever with the mask set. A design that ignored the mask for event-type wake would wake it too early. The event register is exercised for its lifetime. That covers an event that arrives during an interrupt-type sleep and must survive a wait-for-event pulse ignored during that sleep, a held pending bit that must not re-arm it, and the immediate return of a wait-for-event that finds it set. A mistake there shows up as a lost wake or a spurious sleep. The deep-sleep restore latency is counted to the cycle, so an off-by-one in the restore counter moves the wake pulse.

// File: rtl/slumber_pkg.sv
package slumber_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_RESTORE} slp_state_e;
  typedef enum logic {KIND_IRQ, KIND_EVT} slp_kind_e;
endpackage

// File: rtl/slumber_qualify.sv
module slumber_qualify #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 3
) (
  input  logic [N_IRQ-1:0]        pend_i,
  input  logic [N_IRQ-1:0]        en_i,
  input  logic [N_IRQ*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       cur_prio_i,
  output logic                    preempt_o
);
  logic [N_IRQ-1:0] hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    // lower value is more urgent; must be strictly below current level
    assign hit[i] = pend_i[i] & en_i[i] & (prio_i[i*PRIO_W +: PRIO_W] < cur_prio_i);
  end

  assign preempt_o = |hit;
endmodule

// File: rtl/slumber_event.sv
module slumber_event #(
  parameter int N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] pend_i,
  input  logic             arm_i,
  input  logic             consume_i,
  output logic             hit_o
);
  logic [N_IRQ-1:0] pend_q;
  logic             ev_q;
  logic             fresh;

  assign fresh = arm_i & |(pend_i & ~pend_q);
  assign hit_o = ev_q | fresh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ev_q   <= 1'b0;
    end else begin
      pend_q <= pend_i;
      ev_q   <= consume_i ? 1'b0 : (ev_q | fresh);
    end
  end
endmodule

// File: rtl/slumber_seq.sv
module slumber_seq
  import slumber_pkg::*;
#(
  parameter int RESTORE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wfi_i,
  input  logic wfe_i,
  input  logic exc_ret_i,
  input  logic soe_i,
  input  logic deep_i,
  input  logic irq_wake_i,
  input  logic entry_ok_i,
  input  logic evt_i,
  output logic consume_o,
  output logic run_o,
  output logic sleeping_o,
  output logic deep_o,
  output logic wake_o
);
  localparam int CW = $clog2(RESTORE_CYC + 1);

  slp_state_e     state_q, state_d;
  slp_kind_e      kind_q, kind_d;
  logic           deep_q, deep_d;
  logic           wake_q, wake_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           wake_now;

  assign wake_now = (kind_q == KIND_IRQ) ? irq_wake_i : (entry_ok_i | evt_i);

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    deep_d    = deep_q;
    cnt_d     = cnt_q;
    wake_d    = 1'b0;
    consume_o = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (wfi_i || (exc_ret_i && soe_i)) begin
          state_d = ST_SLEEP;
          kind_d  = KIND_IRQ;
          deep_d  = deep_i;
        end else if (wfe_i) begin
          if (evt_i) begin
            consume_o = 1'b1;
          end else begin
            state_d = ST_SLEEP;
            kind_d  = KIND_EVT;
            deep_d  = deep_i;
          end
        end
      end
      ST_SLEEP: begin
        if (wake_now) begin
          consume_o = (kind_q == KIND_EVT);
          if (deep_q) begin
            state_d = ST_RESTORE;
            cnt_d   = CW'(RESTORE_CYC);
          end else begin
            state_d = ST_RUN;
            deep_d  = 1'b0;
            wake_d  = 1'b1;
          end
        end
      end
      ST_RESTORE: begin
        if (cnt_q <= CW'(1)) begin
          state_d = ST_RUN;
          deep_d  = 1'b0;
          wake_d  = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      kind_q  <= KIND_IRQ;
      deep_q  <= 1'b0;
      wake_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      deep_q  <= deep_d;
      wake_q  <= wake_d;
      cnt_q   <= cnt_d;
    end
  end

  assign run_o      = (state_q == ST_RUN);
  assign sleeping_o = !run_o;
  assign deep_o     = sleeping_o & deep_q;
  assign wake_o     = wake_q;
endmodule

// File: rtl/slumber_ctrl.sv
module slumber_ctrl #(
  parameter int N_IRQ       = 8,
  parameter int PRIO_W      = 3,
  parameter int RESTORE_CYC = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wfi_i,
  input  logic                    wfe_i,
  input  logic                    exc_ret_i,
  input  logic                    sleep_on_exit_i,
  input  logic                    send_ev_on_pend_i,
  input  logic                    deep_i,
  input  logic                    primask_i,
  input  logic                    faultmask_i,
  input  logic [N_IRQ-1:0]        irq_pend_i,
  input  logic [N_IRQ-1:0]        irq_en_i,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic [PRIO_W-1:0]       cur_prio_i,
  output logic                    sleeping_o,
  output logic                    deep_o,
  output logic                    wic_en_o,
  output logic                    wake_o,
  output logic                    take_exc_o
);
  logic preempt, irq_wake, entry_ok, evt_hit, consume, run;

  slumber_qualify #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_qual (
    .pend_i     (irq_pend_i),
    .en_i       (irq_en_i),
    .prio_i     (irq_prio_i),
    .cur_prio_i (cur_prio_i),
    .preempt_o  (preempt)
  );

  slumber_event #(.N_IRQ(N_IRQ)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (irq_pend_i),
    .arm_i     (send_ev_on_pend_i),
    .consume_i (consume),
    .hit_o     (evt_hit)
  );

  // interrupt-type sleep ignores primask; handler entry does not
  assign irq_wake = preempt & ~faultmask_i;
  assign entry_ok = irq_wake & ~primask_i;

  slumber_seq #(.RESTORE_CYC(RESTORE_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wfi_i      (wfi_i),
    .wfe_i      (wfe_i),
    .exc_ret_i  (exc_ret_i),
    .soe_i      (sleep_on_exit_i),
    .deep_i     (deep_i),
    .irq_wake_i (irq_wake),
    .entry_ok_i (entry_ok),
    .evt_i      (evt_hit),
    .consume_o  (consume),
    .run_o      (run),
    .sleeping_o (sleeping_o),
    .deep_o     (deep_o),
    .wake_o     (wake_o)
  );

  assign take_exc_o = run & entry_ok;
  assign wic_en_o   = sleeping_o & deep_i;
endmodule

// File: rtl/slumber_ctrl_chk.sv
module slumber_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wfi_i,
  input logic primask_i,
  input logic faultmask_i,
  input logic sleeping_o,
  input logic deep_o,
  input logic wic_en_o,
  input logic wake_o,
  input logic take_exc_o
);
  // R10
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  // R10
  wake_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !sleeping_o);
  // R9
  leave_with_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleeping_o) |-> wake_o);
  // R2
  wfi_enters_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleeping_o && wfi_i) |=> sleeping_o);
  // R4
  take_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_o |-> (!primask_i && !faultmask_i && !sleeping_o));
  // R8
  deep_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_o |-> sleeping_o);
  // R8
  wic_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wic_en_o |-> sleeping_o);
endmodule

bind slumber_ctrl slumber_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wfi_i       (wfi_i),
  .primask_i   (primask_i),
  .faultmask_i (faultmask_i),
  .sleeping_o  (sleeping_o),
  .deep_o      (deep_o),
  .wic_en_o    (wic_en_o),
  .wake_o      (wake_o),
  .take_exc_o  (take_exc_o)
);

// File: tb/slumber_ctrl_test.sv
module slumber_ctrl_test;
  localparam int N   = 8;
  localparam int PW  = 3;
  localparam int RC  = 4;
  localparam int MAX_CYC = 100000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wfi_i = 0, wfe_i = 0, exc_ret_i = 0, soe = 0, sop = 0, deep = 0, pm = 0, fm = 0;
  logic [N-1:0]    pend = '0, en = '0;
  logic [N*PW-1:0] prio = '1;
  logic [PW-1:0]   cur  = '1;
  logic sleeping_o, deep_o, wic_en_o, wake_o, take_exc_o;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  slumber_ctrl #(.N_IRQ(N), .PRIO_W(PW), .RESTORE_CYC(RC)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wfi_i(wfi_i), .wfe_i(wfe_i), .exc_ret_i(exc_ret_i),
    .sleep_on_exit_i(soe), .send_ev_on_pend_i(sop), .deep_i(deep), .primask_i(pm),
    .faultmask_i(fm), .irq_pend_i(pend), .irq_en_i(en), .irq_prio_i(prio),
    .cur_prio_i(cur), .sleeping_o(sleeping_o), .deep_o(deep_o), .wic_en_o(wic_en_o),
    .wake_o(wake_o), .take_exc_o(take_exc_o)
  );

  function automatic bit qual_f(logic [N-1:0] p, logic [N-1:0] e, logic [N*PW-1:0] pr,
                                logic [PW-1:0] c);
    bit q = 0;
    for (int i = 0; i < N; i++)
      if (p[i] && e[i] && pr[i*PW +: PW] < c) q = 1;
    return q;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 0; wfi_i = 0; wfe_i = 0; exc_ret_i = 0; soe = 0; sop = 0; deep = 0;
    pm = 0; fm = 0; pend = '0; en = '0; prio = '1; cur = '1;
    tick();
    rst_ni = 1;
    tick();
  endtask

  task automatic set_irq(int idx, bit p, bit e, int pr);
    pend[idx] = p; en[idx] = e; prio[idx*PW +: PW] = PW'(pr);
  endtask

  task automatic pulse_wfi(); wfi_i = 1; tick(); wfi_i = 0; endtask
  task automatic pulse_wfe(); wfe_i = 1; tick(); wfe_i = 0; endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > MAX_CYC && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, MAX_CYC);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    int n;
    bit q, ew;
    seed_dummy = $urandom(32'h5eed);
    // R1
    tick();
    chk("R1 sleeping in reset", sleeping_o, 0);
    chk("R1 wake in reset", wake_o, 0);
    rst_ni = 1; tick();
    chk("R1 deep", deep_o, 0);
    chk("R1 wic", wic_en_o, 0);
    chk("R1 take", take_exc_o, 0);

    // R2 sleep-on-exit
    exc_ret_i = 1; tick(); exc_ret_i = 0;
    chk("R2 exc_ret without soe", sleeping_o, 0);
    soe = 1; exc_ret_i = 1; tick(); exc_ret_i = 0; soe = 0;
    chk("R2 exc_ret with soe", sleeping_o, 1);

    // R3 priority and masks
    cur = 3'd5;
    set_irq(0, 1, 1, 5); tick();
    chk("R3 equal prio no wake", sleeping_o, 1);
    set_irq(0, 1, 0, 2); tick();
    chk("R3 disabled no wake", sleeping_o, 1);
    en[0] = 1; fm = 1; tick();
    chk("R3 faultmask blocks", sleeping_o, 1);
    fm = 0; pm = 1; tick();
    chk("R4 primask still wakes", sleeping_o, 0);
    chk("R4 wake pulse", wake_o, 1);
    chk("R4 take held", take_exc_o, 0);
    tick();
    chk("R10 wake one cycle", wake_o, 0);
    pm = 0; #1;
    chk("R4 take after primask clear", take_exc_o, 1);
    pend = '0; tick();

    // R5 event-type sleep with primask
    set_irq(0, 1, 1, 2); pm = 1;
    pulse_wfe();
    chk("R5 wfe sleeps", sleeping_o, 1);
    tick();
    chk("R5 primask blocks wfe wake", sleeping_o, 1);
    pm = 0; tick();
    chk("R5 wfe wakes on entry", wake_o, 1);
    chk("R5 take", take_exc_o, 1);
    pend = '0; tick();

    // R6 send-event-on-pend
    sop = 1; set_irq(1, 0, 0, 7);
    pulse_wfe();
    chk("R6 wfe sleeps", sleeping_o, 1);
    pend[1] = 1; tick();
    chk("R6 new pend wakes", wake_o, 1);
    pulse_wfe();
    chk("R6 held pend no event", sleeping_o, 1);
    tick();
    chk("R6 still asleep", sleeping_o, 1);
    set_irq(0, 1, 1, 2); tick();
    chk("R5 qualifying wakes wfe", wake_o, 1);
    pend = '0; tick();

    // R3/R7/R10 event survives ignored wfe in interrupt-type sleep
    pulse_wfi();
    chk("R2 wfi sleeps", sleeping_o, 1);
    pend[1] = 1; tick();
    chk("R3 event does not wake wfi", sleeping_o, 1);
    pulse_wfe();
    chk("R10 wfe ignored while asleep", sleeping_o, 1);
    sop = 0; set_irq(0, 1, 1, 2); tick();
    chk("R3 qualifying wakes wfi", wake_o, 1);
    pend[0] = 0; tick();
    pulse_wfe();
    chk("R7 wfe with event stays run", sleeping_o, 0);
    chk("R7 no wake pulse", wake_o, 0);
    pulse_wfe();
    chk("R7 event consumed", sleeping_o, 1);
    pend[0] = 1; tick();
    chk("R7 wake", wake_o, 1);
    pend = '0; tick();

    // R8/R9 deep sleep
    deep = 1; pulse_wfi();
    chk("R8 deep_o", deep_o, 1);
    chk("R8 wic on", wic_en_o, 1);
    deep = 0; #1;
    chk("R8 wic follows deep_i", wic_en_o, 0);
    chk("R8 deep_o held", deep_o, 1);
    deep = 1;
    pend[0] = 1;
    n = 0;
    for (int k = 1; k <= 20; k++) begin
      tick();
      if (wake_o) begin n = k; break; end
      if (!sleeping_o || take_exc_o) begin
        chk("R9 asleep during restore", {sleeping_o, take_exc_o}, 2);
      end
    end
    chk("R9 restore latency", n, RC + 1);
    chk("R9 deep cleared", deep_o, 0);
    pend = '0; deep = 0; tick();

    // random interrupt-type and event-type trials
    for (int t = 0; t < 300; t++) begin
      bit evt_kind;
      evt_kind = t[0];
      do_reset();
      cur = PW'($urandom);
      if (evt_kind) pulse_wfe(); else pulse_wfi();
      chk(evt_kind ? "R5 random sleep" : "R2 random sleep", sleeping_o, 1);
      pend = N'($urandom); en = N'($urandom); prio = (N*PW)'($urandom);
      pm = 1'($urandom); fm = 1'($urandom); sop = 1'($urandom);
      q = qual_f(pend, en, prio, cur);
      if (evt_kind) ew = (q && !pm && !fm) || (sop && pend != '0);
      else          ew = q && !fm;
      tick();
      chk(evt_kind ? "R6 random wfe wake" : "R3 random wfi wake", sleeping_o, !ew);
      if (ew) chk("R4 random take", take_exc_o, q && !pm && !fm);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule